// File: doc/BRIEF.md
# Modem GPIO Slot Shadow

This block keeps the modem GPIO slot of a codec link (slot 12, a 20-bit payload) in step with a pair of data registers. One register holds the last general-purpose input word the codec sent. The other holds the general-purpose output word that goes back out. A frame-start pulse marks each link frame. On that pulse the block takes in the slot 12 data that was just received, together with its valid tag and the codec's slot 12 request bit. The serializer on either side is outside this block.

An input word is stored only when the codec tagged it valid. The outgoing slot carries the output register's contents. Its valid tag is asserted only when the codec requested slot 12 in the previous frame, which is the request latched at the most recent frame-start pulse. Bit 0 of the incoming payload is the GPIO interrupt bit. When a captured word has it set, a sticky pending flag is set; software clears the flag by writing one, and a mask bit gates the interrupt line. Separate receive and transmit enable flags turn each direction of the shadowing on or off.

Top module: `gpio_slot_shadow`

## Requirements
- R1: After reset the input register, output register, latched request and pending flag are all 0, so every output reads 0.
- R2: On a cycle with frame_start=1, rx_en=1 and in_valid=1, in_data is stored in the input register and appears on gpi_data in the next cycle.
- R3: When frame_start or in_valid is 0, gpi_data keeps its value.
- R4: While rx_en=0, gpi_data keeps its value and the pending flag is not set, whatever the input slot carries.
- R5: A write (gpo_wr=1) loads gpo_wdata into the output register. While tx_en=1, out_data shows it from the next cycle on.
- R6: out_valid equals tx_en AND the value of req that was present on the most recent cycle with frame_start=1.
- R7: While tx_en=0, out_valid and out_data are both 0.
- R8: A capture (as in R2) whose in_data bit 0 is 1 sets irq_pending in the next cycle.
- R9: irq_clr=1 clears irq_pending in the next cycle. If a set (R8) arrives in the same cycle, the set wins.
- R10: irq equals irq_pending AND irq_mask.
- R11: A change of req on a cycle without frame_start has no effect on out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse per link frame; qualifies in_data, in_valid and req |
| rx_en | input | 1 | Receive-direction slot enable |
| tx_en | input | 1 | Transmit-direction slot enable |
| in_data | input | 20 | Received slot 12 payload |
| in_valid | input | 1 | Codec's valid tag for received slot 12 |
| req | input | 1 | Codec's request bit for slot 12 |
| gpo_wr | input | 1 | Output-register write strobe |
| gpo_wdata | input | 20 | Output-register write data |
| irq_clr | input | 1 | Write-one-to-clear for the pending flag |
| irq_mask | input | 1 | Interrupt enable |
| out_data | output | 20 | Slot 12 payload to transmit |
| out_valid | output | 1 | Valid tag for transmitted slot 12 |
| gpi_data | output | 20 | Input-register readback |
| irq_pending | output | 1 | Sticky GPIO interrupt status |
| irq | output | 1 | Masked interrupt request |

## Verification
Every register result (gpi_data, the latched request, the output register and irq_pending) is due one clock edge after the cycle that carries its stimulus. out_valid, out_data and irq also follow tx_en and irq_mask within the same cycle. The bench sets inputs just after a rising edge. It then advances the reference model by exactly one edge, and compares every output 1 time unit after that edge, so both the registered and the combinational paths are checked in the cycle they are due. Directed cases cover a set and a clear in the same cycle, request changes between frames, and disabled directions. Seeded random traffic covers the rest.

// File: rtl/s12_pkg.sv
package s12_pkg;

   localparam int unsigned SLOT_W_DEF = 20;
   localparam int unsigned INT_BIT_DEF = 0;

   typedef enum logic {
      PRIO_CLEAR = 1'b0,
      PRIO_SET   = 1'b1
   } irq_prio_e;

   function automatic logic sticky_next(input logic cur, input logic set,
                                        input logic clr, input irq_prio_e prio);
      logic nxt;
      nxt = cur;
      if (prio == PRIO_SET) begin
         if (set)      nxt = 1'b1;
         else if (clr) nxt = 1'b0;
      end else begin
         if (clr)      nxt = 1'b0;
         else if (set) nxt = 1'b1;
      end
      return nxt;
   endfunction

endpackage

// File: rtl/s12_gpi_capture.sv
module s12_gpi_capture #(
   parameter int unsigned W       = s12_pkg::SLOT_W_DEF,
   parameter int unsigned INT_BIT = s12_pkg::INT_BIT_DEF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_start,
   input  logic         rx_en,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic [W-1:0] gpi_q,
   output logic         int_hit
);
   logic take;

   if (W < 1) begin : g_bad_w
      $error("s12_gpi_capture: W must be at least 1");
   end
   if (INT_BIT >= W) begin : g_bad_bit
      $error("s12_gpi_capture: INT_BIT outside payload");
   end

   assign take    = frame_start & rx_en & in_valid;
   assign int_hit = take & in_data[INT_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    gpi_q <= '0;
      else if (take) gpi_q <= in_data;
   end
endmodule

// File: rtl/s12_gpo_emit.sv
module s12_gpo_emit #(
   parameter int unsigned W = s12_pkg::SLOT_W_DEF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_start,
   input  logic         tx_en,
   input  logic         req,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] out_data,
   output logic         out_valid
);
   logic [W-1:0] gpo_q;
   logic         req_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  gpo_q <= '0;
      else if (wr) gpo_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           req_prev_q <= 1'b0;
      else if (frame_start) req_prev_q <= req;
   end

   always_comb begin
      out_valid = tx_en & req_prev_q;
      out_data  = tx_en ? gpo_q : '0;
   end
endmodule

// File: rtl/s12_irq_sticky.sv
module s12_irq_sticky #(
   parameter s12_pkg::irq_prio_e PRIO = s12_pkg::PRIO_SET
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic mask,
   output logic pend,
   output logic irq
);
   logic pend_d;

   if (PRIO == s12_pkg::PRIO_SET) begin : g_set_wins
      assign pend_d = set | (pend & ~clr);
   end else begin : g_clr_wins
      assign pend_d = s12_pkg::sticky_next(pend, set, clr, PRIO);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= pend_d;
   end

   assign irq = pend & mask;
endmodule

// File: rtl/gpio_slot_shadow.sv
module gpio_slot_shadow #(
   parameter int unsigned        W       = s12_pkg::SLOT_W_DEF,
   parameter int unsigned        INT_BIT = s12_pkg::INT_BIT_DEF,
   parameter s12_pkg::irq_prio_e PRIO    = s12_pkg::PRIO_SET
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_start,
   input  logic         rx_en,
   input  logic         tx_en,
   input  logic [W-1:0] in_data,
   input  logic         in_valid,
   input  logic         req,
   input  logic         gpo_wr,
   input  logic [W-1:0] gpo_wdata,
   input  logic         irq_clr,
   input  logic         irq_mask,
   output logic [W-1:0] out_data,
   output logic         out_valid,
   output logic [W-1:0] gpi_data,
   output logic         irq_pending,
   output logic         irq
);
   logic int_hit;

   s12_gpi_capture #(.W(W), .INT_BIT(INT_BIT)) u_cap (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rx_en(rx_en),
      .in_valid(in_valid), .in_data(in_data), .gpi_q(gpi_data), .int_hit(int_hit)
   );

   s12_gpo_emit #(.W(W)) u_emit (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .tx_en(tx_en),
      .req(req), .wr(gpo_wr), .wdata(gpo_wdata),
      .out_data(out_data), .out_valid(out_valid)
   );

   s12_irq_sticky #(.PRIO(PRIO)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(int_hit), .clr(irq_clr), .mask(irq_mask),
      .pend(irq_pending), .irq(irq)
   );
endmodule

// File: rtl/s12_shadow_chk.sv
module s12_shadow_chk #(
   parameter int unsigned W = 20
) (
   input logic         clk,
   input logic         rst_n,
   input logic         frame_start,
   input logic         rx_en,
   input logic         tx_en,
   input logic [W-1:0] in_data,
   input logic         in_valid,
   input logic         req,
   input logic         irq_clr,
   input logic [W-1:0] out_data,
   input logic         out_valid,
   input logic [W-1:0] gpi_data,
   input logic         irq_pending,
   input logic         irq
);
   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && rx_en && in_valid) |=> gpi_data == $past(in_data));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_start && rx_en && in_valid) |=> $stable(gpi_data));

   assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && rx_en && in_valid && in_data[0]) |=> irq_pending);

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !(frame_start && rx_en && in_valid && in_data[0])) |=> !irq_pending);

   assert_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (out_valid == (tx_en && $past(req))));

   assert_txoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> (!out_valid && out_data == '0));

   assert_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_pending |-> !irq);
endmodule

bind gpio_slot_shadow s12_shadow_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rx_en(rx_en),
   .tx_en(tx_en), .in_data(in_data), .in_valid(in_valid), .req(req),
   .irq_clr(irq_clr), .out_data(out_data), .out_valid(out_valid),
   .gpi_data(gpi_data), .irq_pending(irq_pending), .irq(irq)
);

// File: tb/tb_gpio_slot_shadow.sv
module tb_gpio_slot_shadow;
   localparam int CLK_PERIOD = 10;
   localparam int W = 20;
   localparam int WATCHDOG = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 0, rx_en = 0, tx_en = 0, in_valid = 0, req = 0;
   logic gpo_wr = 0, irq_clr = 0, irq_mask = 0;
   logic [W-1:0] in_data = '0, gpo_wdata = '0;
   logic [W-1:0] out_data, gpi_data;
   logic out_valid, irq_pending, irq;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   logic [W-1:0] m_gpi = '0, m_gpo = '0;
   logic m_req = 0, m_pend = 0;

   gpio_slot_shadow dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rx_en(rx_en),
      .tx_en(tx_en), .in_data(in_data), .in_valid(in_valid), .req(req),
      .gpo_wr(gpo_wr), .gpo_wdata(gpo_wdata), .irq_clr(irq_clr),
      .irq_mask(irq_mask), .out_data(out_data), .out_valid(out_valid),
      .gpi_data(gpi_data), .irq_pending(irq_pending), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [W-1:0] exp_out_data(input logic en, input logic [W-1:0] g);
      return en ? g : '0;
   endfunction

   function automatic logic exp_pend_next(input logic cur, input logic set, input logic clr);
      return set ? 1'b1 : (clr ? 1'b0 : cur);
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(input string ctx);
      chk({ctx, " R2/R3/R4 gpi_data"}, gpi_data, m_gpi);
      chk({ctx, " R6/R11 out_valid"}, W'(out_valid), W'(tx_en & m_req));
      chk({ctx, " R5/R7 out_data"}, out_data, exp_out_data(tx_en, m_gpo));
      chk({ctx, " R8/R9 irq_pending"}, W'(irq_pending), W'(m_pend));
      chk({ctx, " R10 irq"}, W'(irq), W'(m_pend & irq_mask));
   endtask

   task automatic step(input string ctx);
      logic cap;
      @(posedge clk);
      cap = frame_start & rx_en & in_valid;
      m_pend = exp_pend_next(m_pend, cap & in_data[0], irq_clr);
      if (cap) m_gpi = in_data;
      if (gpo_wr) m_gpo = gpo_wdata;
      if (frame_start) m_req = req;
      #1;
      check_all(ctx);
   endtask

   task automatic idle();
      frame_start = 0; in_valid = 0; gpo_wr = 0; irq_clr = 0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5107_0C12);
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state with enables on
      tx_en = 1; rx_en = 1; irq_mask = 1;
      #1;
      chk("R1 gpi_data", gpi_data, '0);
      chk("R1 out_data", out_data, '0);
      chk("R1 out_valid", W'(out_valid), '0);
      chk("R1 irq_pending", W'(irq_pending), '0);
      chk("R1 irq", W'(irq), '0);
      @(negedge clk);
      rst_n = 1;
      @(posedge clk); #1;

      // R2 + R8: valid capture with interrupt bit
      frame_start = 1; in_valid = 1; in_data = 20'hA5A5B; req = 1;
      step("dir capture");
      idle();
      step("dir after capture");
      // R3: invalid tag, no capture
      frame_start = 1; in_valid = 0; in_data = 20'h12345; req = 0;
      step("dir invalid tag");
      idle(); in_data = 20'hFFFFF; in_valid = 1;
      step("dir no frame");
      // R9: set and clear together, set wins
      in_valid = 0; req = 1; frame_start = 1;
      step("dir req latch");
      frame_start = 1; in_valid = 1; in_data = 20'h00003; irq_clr = 1;
      step("dir set vs clear");
      idle(); irq_clr = 1;
      step("dir clear");
      idle();
      // R11: req change without frame_start
      req = 0;
      step("dir req between frames R11");
      // R5: gpo write
      gpo_wr = 1; gpo_wdata = 20'h3C3C3;
      step("dir gpo write");
      idle();
      // R7: tx disabled
      tx_en = 0;
      step("dir tx off R7");
      tx_en = 1;
      // R4: rx disabled
      rx_en = 0; frame_start = 1; in_valid = 1; in_data = 20'h00001;
      step("dir rx off R4");
      idle(); rx_en = 1;
      // R10: mask off
      frame_start = 1; in_valid = 1; in_data = 20'h00011;
      irq_mask = 0;
      step("dir masked R10");
      idle();
      step("dir masked hold");

      for (int i = 0; i < 3000; i++) begin
         frame_start = ($urandom % 6) == 0;
         in_valid    = $urandom % 2;
         in_data     = W'($urandom);
         req         = $urandom % 2;
         rx_en       = ($urandom % 8) != 0;
         tx_en       = ($urandom % 8) != 0;
         gpo_wr      = ($urandom % 10) == 0;
         gpo_wdata   = W'($urandom);
         irq_clr     = ($urandom % 7) == 0;
         irq_mask    = $urandom % 2;
         step("rand");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule